// File: doc/BRIEF.md
# I2C-to-1-Wire Bridge Command Core

This block is the command side of a bridge that lets an I2C host drive up to eight 1-Wire segments. The byte framer upstream presents each host write as one command byte plus an optional parameter byte in a single cycle. The core decodes it, updates a small set of registers, and hands 1-Wire work to a separate slot-timing engine over a start/done handshake. Host reads take no address. The read data output always shows the register chosen by an internal read pointer, and every command moves that pointer as a side effect.

Configuration writes carry a check nibble and are dropped if the check fails. Channel selection uses fixed codes, and the channel register reads back a second, different code set. A status byte holds the engine results, a busy flag, a device-reset flag and the live line level.

Top module: `owbr_cmd_core`

## Requirements
- R1: After rst_ni or a device-reset command (0xF0): configuration is 0, channel is 0, the pointer selects status, status reads 0x18 while line_lvl_i is 1, and busy is cleared. A command in the very next cycle is accepted.
- R2: rd_data_o shows the register the pointer selects. Set-pointer (0xE1) takes parameter 0xF0 for status, 0xE1 for data, 0xD2 for channel and 0xC3 for configuration.
- R3: An accepted configuration write (0xD2) leaves the pointer on configuration. An accepted channel select (0xC3) leaves it on channel. Every other accepted command except set-pointer leaves it on status.
- R4: A configuration write is accepted only when parameter bits 7:4 equal the complement of bits 3:0. Bits 3:0 then drive cfg_o, and the register reads back with bits 7:4 zero.
- R5: An accepted configuration write clears the device-reset flag (status bit 4).
- R6: Channel select codes F0,E1,D2,C3,B4,A5,96,87 pick channels 0..7, up to NUM_CH. The channel register reads B8,B1,AA,A3,9C,95,8E,87 respectively.
- R7: A rejected configuration write, an unknown channel or pointer code, an unknown command, or a command that needs a parameter arriving without one changes no state.
- R8: An accepted 1-Wire command (0xB4 reset, 0x87 bit, 0xA5 write byte, 0x96 read byte, 0x78 triplet) raises eng_start_o for exactly one cycle, starting the cycle after. It presents eng_op_o (0 reset, 1 bit, 2 write, 3 read, 4 triplet), eng_arg_o equal to the parameter byte, eng_chan_o equal to the current channel, and sets busy (status bit 0).
- R9: While busy, 1-Wire commands are ignored and produce no start.
- R10: eng_done_i while busy clears busy. A reset operation loads presence (bit 1) and short (bit 2). A bit operation loads bit 5. A triplet loads bits 5, 6 and 7. A read byte loads the data register. A done while not busy has no effect.
- R11: Status bit 3 follows line_lvl_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command byte present this cycle |
| cmd_i | input | 8 | Command code |
| par_valid_i | input | 1 | Parameter byte present with command |
| par_i | input | 8 | Parameter byte |
| line_lvl_i | input | 1 | Sampled 1-Wire line level |
| rd_data_o | output | 8 | Register selected by the read pointer |
| cfg_o | output | 4 | Active configuration bits |
| eng_start_o | output | 1 | One-cycle launch pulse to the bus engine |
| eng_op_o | output | 3 | Operation code for the engine |
| eng_arg_o | output | 8 | Parameter byte for the engine |
| eng_chan_o | output | 3 | Channel for the operation |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_ppd_i | input | 1 | Presence result |
| eng_sd_i | input | 1 | Short result |
| eng_sbr_i | input | 1 | Single-bit / first triplet bit result |
| eng_tsb_i | input | 1 | Second triplet bit |
| eng_dir_i | input | 1 | Triplet direction taken |
| eng_rdata_i | input | 8 | Byte read from the bus |

## Verification
A pointer left on the wrong register shows on rd_data_o one cycle after the command that moved it. That makes pointer bugs visible on the very next host read. A wrongly accepted configuration or channel code shows the same way, once the bench reads that register back. A busy flag stuck high or released too early shows as a missing or extra eng_start_o pulse on the next 1-Wire command. Result bits latched in the wrong field appear in status bits 1, 2, 5, 6 or 7 one cycle after eng_done_i.

// File: rtl/owbr_pkg.sv
package owbr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CH_W   = 3;

  typedef enum logic [1:0] {PTR_STAT, PTR_DATA, PTR_CHAN, PTR_CFG} rptr_e;
  typedef enum logic [2:0] {OP_RST = 3'd0, OP_BIT = 3'd1, OP_WR = 3'd2,
                            OP_RD = 3'd3, OP_TRI = 3'd4} eng_op_e;
  typedef enum logic [2:0] {K_NONE, K_DEVRST, K_SETPTR, K_CHSEL, K_WRCFG,
                            K_WIRE} kind_e;

  typedef struct packed {
    logic dir, tsb, sbr, rst, ll, sd, ppd, busy;
  } stat_t;

  function automatic logic [BYTE_W-1:0] chan_wr_code(input logic [CH_W-1:0] n);
    return 8'hF0 - 8'(n) * 8'h0F;
  endfunction

  function automatic logic [BYTE_W-1:0] chan_rd_code(input logic [CH_W-1:0] n);
    return 8'hB8 - 8'(n) * 8'h07;
  endfunction
endpackage

// File: rtl/owbr_cmd_dec.sv
module owbr_cmd_dec
  import owbr_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] par_i,
  input  logic              par_valid_i,
  output kind_e             kind_o,
  output eng_op_e           op_o,
  output rptr_e             ptr_sel_o,
  output logic              ptr_ok_o,
  output logic [CH_W-1:0]   chan_idx_o,
  output logic              chan_ok_o,
  output logic              cfg_ok_o
);
  kind_e raw_kind;
  logic  needs_par;

  always_comb begin
    raw_kind  = K_NONE;
    op_o      = OP_RST;
    needs_par = 1'b1;
    unique case (cmd_i)
      8'hF0: begin raw_kind = K_DEVRST; needs_par = 1'b0; end
      8'hE1: raw_kind = K_SETPTR;
      8'hC3: raw_kind = K_CHSEL;
      8'hD2: raw_kind = K_WRCFG;
      8'hB4: begin raw_kind = K_WIRE; op_o = OP_RST; needs_par = 1'b0; end
      8'h87: begin raw_kind = K_WIRE; op_o = OP_BIT; end
      8'hA5: begin raw_kind = K_WIRE; op_o = OP_WR;  end
      8'h96: begin raw_kind = K_WIRE; op_o = OP_RD; needs_par = 1'b0; end
      8'h78: begin raw_kind = K_WIRE; op_o = OP_TRI; end
      default: raw_kind = K_NONE;
    endcase
    kind_o = (needs_par && !par_valid_i) ? K_NONE : raw_kind;
  end

  always_comb begin
    ptr_ok_o  = 1'b1;
    ptr_sel_o = PTR_STAT;
    unique case (par_i)
      8'hF0: ptr_sel_o = PTR_STAT;
      8'hE1: ptr_sel_o = PTR_DATA;
      8'hD2: ptr_sel_o = PTR_CHAN;
      8'hC3: ptr_sel_o = PTR_CFG;
      default: ptr_ok_o = 1'b0;
    endcase
  end

  always_comb begin
    chan_ok_o  = 1'b0;
    chan_idx_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (par_i == chan_wr_code(CH_W'(i))) begin
        chan_ok_o  = 1'b1;
        chan_idx_o = CH_W'(i);
      end
    end
  end

  assign cfg_ok_o = (par_i[7:4] == ~par_i[3:0]);
endmodule

// File: rtl/owbr_rd_mux.sv
module owbr_rd_mux
  import owbr_pkg::*;
(
  input  rptr_e             ptr_i,
  input  stat_t             stat_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [3:0]        cfg_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  always_comb begin
    unique case (ptr_i)
      PTR_STAT: rd_data_o = stat_i;
      PTR_DATA: rd_data_o = data_i;
      PTR_CHAN: rd_data_o = chan_rd_code(chan_i);
      default:  rd_data_o = {4'h0, cfg_i};
    endcase
  end
endmodule

// File: rtl/owbr_cmd_core.sv
module owbr_cmd_core
  import owbr_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [7:0]  cmd_i,
  input  logic        par_valid_i,
  input  logic [7:0]  par_i,
  input  logic        line_lvl_i,
  output logic [7:0]  rd_data_o,
  output logic [3:0]  cfg_o,
  output logic        eng_start_o,
  output logic [2:0]  eng_op_o,
  output logic [7:0]  eng_arg_o,
  output logic [2:0]  eng_chan_o,
  input  logic        eng_done_i,
  input  logic        eng_ppd_i,
  input  logic        eng_sd_i,
  input  logic        eng_sbr_i,
  input  logic        eng_tsb_i,
  input  logic        eng_dir_i,
  input  logic [7:0]  eng_rdata_i
);
  kind_e             kind;
  eng_op_e           dec_op;
  rptr_e             ptr_sel;
  logic              ptr_ok, chan_ok, cfg_ok;
  logic [CH_W-1:0]   chan_idx;

  rptr_e             ptr_q;
  logic [3:0]        cfg_q;
  logic [CH_W-1:0]   chan_q, eng_chan_q;
  logic [BYTE_W-1:0] data_q, arg_q;
  eng_op_e           op_q;
  logic              start_q, busy_q, rst_flag_q;
  logic              dir_q, tsb_q, sbr_q, sd_q, ppd_q;
  stat_t             stat;

  owbr_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
    .cmd_i      (cmd_i),
    .par_i      (par_i),
    .par_valid_i(par_valid_i),
    .kind_o     (kind),
    .op_o       (dec_op),
    .ptr_sel_o  (ptr_sel),
    .ptr_ok_o   (ptr_ok),
    .chan_idx_o (chan_idx),
    .chan_ok_o  (chan_ok),
    .cfg_ok_o   (cfg_ok)
  );

  assign stat = '{dir: dir_q, tsb: tsb_q, sbr: sbr_q, rst: rst_flag_q,
                  ll: line_lvl_i, sd: sd_q, ppd: ppd_q, busy: busy_q};

  owbr_rd_mux u_rd (
    .ptr_i    (ptr_q),
    .stat_i   (stat),
    .data_i   (data_q),
    .chan_i   (chan_q),
    .cfg_i    (cfg_q),
    .rd_data_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= PTR_STAT; cfg_q <= '0; chan_q <= '0; eng_chan_q <= '0;
      data_q <= '0; arg_q <= '0; op_q <= OP_RST; start_q <= 1'b0;
      busy_q <= 1'b0; rst_flag_q <= 1'b1;
      dir_q <= 1'b0; tsb_q <= 1'b0; sbr_q <= 1'b0; sd_q <= 1'b0; ppd_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      // engine completion: load results by operation
      if (busy_q && eng_done_i) begin
        busy_q <= 1'b0;
        unique case (op_q)
          OP_RST: begin ppd_q <= eng_ppd_i; sd_q <= eng_sd_i; end
          OP_BIT: sbr_q <= eng_sbr_i;
          OP_TRI: begin sbr_q <= eng_sbr_i; tsb_q <= eng_tsb_i; dir_q <= eng_dir_i; end
          OP_RD:  data_q <= eng_rdata_i;
          default: ;
        endcase
      end
      if (cmd_valid_i) begin
        unique case (kind)
          K_DEVRST: begin
            ptr_q <= PTR_STAT; cfg_q <= '0; chan_q <= '0; busy_q <= 1'b0;
            rst_flag_q <= 1'b1;
            dir_q <= 1'b0; tsb_q <= 1'b0; sbr_q <= 1'b0; sd_q <= 1'b0; ppd_q <= 1'b0;
          end
          K_SETPTR: if (ptr_ok) ptr_q <= ptr_sel;
          K_CHSEL: if (chan_ok) begin
            chan_q <= chan_idx; ptr_q <= PTR_CHAN;
          end
          K_WRCFG: if (cfg_ok) begin
            cfg_q <= par_i[3:0]; ptr_q <= PTR_CFG; rst_flag_q <= 1'b0;
          end
          K_WIRE: if (!busy_q) begin
            ptr_q <= PTR_STAT; busy_q <= 1'b1; start_q <= 1'b1;
            op_q <= dec_op; arg_q <= par_i; eng_chan_q <= chan_q;
          end
          default: ;
        endcase
      end
    end
  end

  assign cfg_o       = cfg_q;
  assign eng_start_o = start_q;
  assign eng_op_o    = op_q;
  assign eng_arg_o   = arg_q;
  assign eng_chan_o  = eng_chan_q;

  // R8: a launch is seen only on the cycle busy first rises
  a_r8_start_on_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (busy_q && !$past(busy_q)));
  // R8: launch is a single-cycle pulse
  a_r8_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  // R9: wire command while busy gives no launch
  a_r9_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && kind == K_WIRE && busy_q) |=> !eng_start_o);
  // R10: done releases busy
  a_r10_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && eng_done_i) |=> !busy_q);
  // R7: without a command no register moves
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> ($stable(cfg_q) && $stable(chan_q) && $stable(ptr_q)));
  // R6: channel never exceeds the configured count
  a_r6_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(chan_q) < NUM_CH);
endmodule

// File: tb/owbr_cmd_core_tb_top.sv
module owbr_cmd_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, par_valid = 1'b0, line_lvl = 1'b1;
  logic [7:0] cmd = '0, par = '0;
  logic [7:0] rd_data, eng_arg, eng_rdata = '0;
  logic [3:0] cfg;
  logic       eng_start, eng_done = 1'b0;
  logic [2:0] eng_op, eng_chan;
  logic       eng_ppd = 1'b0, eng_sd = 1'b0, eng_sbr = 1'b0, eng_tsb = 1'b0, eng_dir = 1'b0;

  int n_chk = 0, n_fail = 0, n_start = 0;
  logic       seen_start;
  logic [2:0] seen_op, seen_chan;
  logic [7:0] seen_arg;

  always #5 clk = ~clk;

  owbr_cmd_core #(.NUM_CH(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .par_valid_i(par_valid), .par_i(par), .line_lvl_i(line_lvl),
    .rd_data_o(rd_data), .cfg_o(cfg), .eng_start_o(eng_start), .eng_op_o(eng_op),
    .eng_arg_o(eng_arg), .eng_chan_o(eng_chan), .eng_done_i(eng_done),
    .eng_ppd_i(eng_ppd), .eng_sd_i(eng_sd), .eng_sbr_i(eng_sbr),
    .eng_tsb_i(eng_tsb), .eng_dir_i(eng_dir), .eng_rdata_i(eng_rdata)
  );

  always @(posedge clk) if (eng_start) n_start++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] c, input logic [7:0] p, input logic pv);
    cmd = c; par = p; par_valid = pv; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; par_valid = 1'b0;
    seen_start = eng_start; seen_op = eng_op; seen_arg = eng_arg; seen_chan = eng_chan;
  endtask

  task automatic eng_finish(input logic ppd, input logic sd, input logic sbr,
                            input logic tsb, input logic dir, input logic [7:0] rdat);
    eng_ppd = ppd; eng_sd = sd; eng_sbr = sbr; eng_tsb = tsb; eng_dir = dir;
    eng_rdata = rdat; eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // {par_valid, cmd, par, expected rd_data}
  localparam logic [24:0] VEC [17] = '{
    {1'b1, 8'hD2, 8'hE1, 8'h01},  // R4 R3 valid cfg
    {1'b1, 8'hE1, 8'hF0, 8'h08},  // R5 R2 rst flag cleared
    {1'b1, 8'hD2, 8'h3A, 8'h08},  // R7 bad complement
    {1'b1, 8'hE1, 8'hC3, 8'h01},  // R4 cfg unchanged
    {1'b1, 8'hC3, 8'h96, 8'h8E},  // R6 channel 6
    {1'b1, 8'hC3, 8'h11, 8'h8E},  // R7 bad channel code
    {1'b1, 8'hE1, 8'hAA, 8'h8E},  // R7 bad pointer code
    {1'b1, 8'h55, 8'h00, 8'h8E},  // R7 unknown command
    {1'b1, 8'hE1, 8'hD2, 8'h8E},  // R2 channel pointer
    {1'b1, 8'hC3, 8'hF0, 8'hB8},  // R6 channel 0
    {1'b1, 8'hC3, 8'h87, 8'h87},  // R6 channel 7
    {1'b1, 8'hD2, 8'h78, 8'h08},  // R4 speed bit
    {1'b1, 8'hE1, 8'hE1, 8'h00},  // R2 data register
    {1'b0, 8'hF0, 8'h00, 8'h18},  // R1 device reset
    {1'b1, 8'hE1, 8'hC3, 8'h00},  // R1 cfg cleared
    {1'b1, 8'hE1, 8'hD2, 8'hB8},  // R1 channel cleared
    {1'b0, 8'hD2, 8'hE1, 8'hB8}   // R7 missing parameter
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", rd_data, 8'h18);
    check("R1 reset cfg_o", {4'h0, cfg}, 8'h00);

    for (int i = 0; i < 17; i++) begin
      do_cmd(VEC[i][23:16], VEC[i][15:8], VEC[i][24]);
      check($sformatf("R2/R3/R4/R6/R7 vector %0d", i), rd_data, VEC[i][7:0]);
    end

    // R11 live line level
    do_cmd(8'hE1, 8'hF0, 1'b1);
    line_lvl = 1'b0; #1;
    check("R11 line low", rd_data, 8'h10);
    line_lvl = 1'b1; #1;
    check("R11 line high", rd_data, 8'h18);

    // R8 launch with channel
    do_cmd(8'hC3, 8'hD2, 1'b1);
    do_cmd(8'hB4, 8'h00, 1'b0);
    check("R8 start", {7'h0, seen_start}, 8'h01);
    check("R8 op reset", {5'h0, seen_op}, 8'h00);
    check("R8 chan", {5'h0, seen_chan}, 8'h02);
    check("R8 R3 busy status", rd_data, 8'h19);

    // R9 ignored while busy, pointer untouched
    do_cmd(8'hE1, 8'hC3, 1'b1);
    do_cmd(8'hA5, 8'h11, 1'b1);
    check("R9 no start", {7'h0, seen_start}, 8'h00);
    check("R9 pointer kept", rd_data, 8'h00);
    check("R9 start count", 8'(n_start), 8'd1);

    // R10 reset result
    eng_finish(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    do_cmd(8'hE1, 8'hF0, 1'b1);
    check("R10 presence/short", rd_data, 8'h1E);

    // R10 single bit
    do_cmd(8'h87, 8'h80, 1'b1);
    check("R8 op bit", {5'h0, seen_op}, 8'h01);
    check("R8 arg bit", seen_arg, 8'h80);
    eng_finish(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R10 bit result", rd_data, 8'h3E);

    // R10 triplet
    do_cmd(8'h78, 8'h00, 1'b1);
    check("R8 op triplet", {5'h0, seen_op}, 8'h04);
    eng_finish(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    check("R10 triplet result", rd_data, 8'hDE);

    // R10 read byte
    do_cmd(8'h96, 8'h00, 1'b0);
    check("R8 op read", {5'h0, seen_op}, 8'h03);
    eng_finish(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
    do_cmd(8'hE1, 8'hE1, 1'b1);
    check("R10 data byte", rd_data, 8'h3C);

    // R8 write byte, flags untouched
    do_cmd(8'hA5, 8'h5E, 1'b1);
    check("R8 op write", {5'h0, seen_op}, 8'h02);
    check("R8 arg write", seen_arg, 8'h5E);
    eng_finish(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);
    check("R10 write keeps flags", rd_data, 8'hDE);

    // R1 device reset while busy, then immediate new command
    do_cmd(8'hB4, 8'h00, 1'b0);
    do_cmd(8'hF0, 8'h00, 1'b0);
    check("R1 reset clears busy", rd_data, 8'h18);
    eng_finish(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    check("R10 stray done ignored", rd_data, 8'h18);
    do_cmd(8'hB4, 8'h00, 1'b0);
    check("R1 ready next cycle", {7'h0, seen_start}, 8'h01);
    eng_finish(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

    // R4 R5 cfg_o and flag
    do_cmd(8'hD2, 8'hE1, 1'b1);
    check("R4 cfg_o", {4'h0, cfg}, 8'h01);
    do_cmd(8'hE1, 8'hF0, 1'b1);
    check("R5 flag cleared", rd_data, 8'h08);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule